// File: doc/BRIEF.md
# Strobed Input Port Handshake

This block handles the receive side of a strobed parallel input port, one 8-bit channel wide. An external device places a byte on the port pins and pulls its active-low strobe. The block captures the byte into a holding register and raises a buffer-full flag back toward the device. When the processor has enabled interrupts for this port, the block also raises an interrupt request once the strobe has returned high.

A processor read of the port drops the interrupt request as soon as the read strobe goes low. The buffer-full flag stays up until the read strobe returns high, so the device does not send the next byte while the processor is still reading.

The interrupt enable is a single flip-flop. It is written through the bit set/reset path of the companion control port: a write that names the enable's pin index loads the value bit. A status byte places the flag, request and enable bits at their pin positions, which a parameter chooses for the first or second port. Bus decoding and the mode register sit outside the block. They arrive as a decoded read strobe, a decoded bit set/reset write and a mode-active level. All inputs are sampled on the block clock.

Top module: `strobed_input_port`

## Requirements
- R1: Synchronous reset clears the captured byte, the buffer-full flag, the interrupt request and the interrupt enable to 0.
- R2: While the mode is active and `stbN` is sampled low, `dataOut` takes `padData` at that clock edge. While `stbN` is high, `dataOut` holds its value.
- R3: `ibf` is 1 after every clock edge at which the mode is active and `stbN` is sampled low.
- R4: `ibf` clears at the edge where `rdN` is sampled high after being low at the previous edge, unless `stbN` is low at that edge, in which case the set wins.
- R5: `intr` is 1 after an edge exactly when, at that edge, the mode is active, `inte` and `ibf` are 1, `stbN` is high, and `rdN` is high both at that edge and at the previous edge.
- R6: An edge at which `rdN` is sampled low leaves `intr` at 0.
- R7: A bit set/reset write (`bsrWrite`=1) whose 3-bit `bsrBit` equals the enable pin index (4 for the first port, 2 for the second) loads `bsrVal` into `inte`. Writes naming any other index leave `inte` unchanged.
- R8: `statusC` carries `ibf` at bit 5, `inte` at bit 4 and `intr` at bit 3 for the first port. For the second port it carries `ibf` at bit 1, `inte` at bit 2 and `intr` at bit 0. All other bits are 0.
- R9: While `modeActive` is 0, `ibf` and `intr` are forced to 0 and the strobe does not change `dataOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| modeActive | input | 1 | Port configured for strobed input |
| stbN | input | 1 | Device strobe, active low |
| padData | input | 8 | Byte presented by the device |
| rdN | input | 1 | Decoded processor read of this port, active low |
| bsrWrite | input | 1 | Decoded bit set/reset control write |
| bsrBit | input | 3 | Pin index named by the bit set/reset write |
| bsrVal | input | 1 | Value carried by the bit set/reset write |
| dataOut | output | 8 | Captured byte |
| ibf | output | 1 | Buffer-full flag to the device |
| intr | output | 1 | Interrupt request to the processor |
| inte | output | 1 | Interrupt enable flip-flop |
| statusC | output | 8 | Status bits at their control-port pin positions |

## Verification
The hardest case to reach is a strobe arriving while a read is still in progress. Here the full flag has to be set again in the cycle the read strobe rises, and the request has to stay low until the read has been high for two edges. A directed sequence overlaps the two strobes to reach this case. A long pseudo-random run then crosses strobe, read, enable writes and mode drops in every ordering, while a cycle-accurate model built from the requirements predicts each output. A sweep over all eight bit set/reset indices on both port variants shows that only the enable index has any effect.

// File: rtl/sip_pkg.sv
package sip_pkg;
  typedef struct packed {
    logic capture;
    logic ibf;
    logic intr;
    logic inte;
  } sipCtrl_t;

  function automatic int intePos(input bit isPortA);
    return isPortA ? 4 : 2;
  endfunction
  function automatic int ibfPos(input bit isPortA);
    return isPortA ? 5 : 1;
  endfunction
  function automatic int intrPos(input bit isPortA);
    return isPortA ? 3 : 0;
  endfunction
endpackage

// File: rtl/sip_ctrl.sv
module sip_ctrl
  import sip_pkg::*;
#(
  parameter int INTE_POS = 4,
  parameter int BIT_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modeActive,
  input  logic             stbN,
  input  logic             rdN,
  input  logic             bsrWrite,
  input  logic [BIT_W-1:0] bsrBit,
  input  logic             bsrVal,
  output sipCtrl_t         ctrl
);
  logic ibfQ, intrQ, inteQ, rdPrevQ;
  logic rdRise, stbLow, inteHit;

  assign stbLow  = modeActive && !stbN;
  assign rdRise  = rdN && !rdPrevQ;
  assign inteHit = bsrWrite && (bsrBit == BIT_W'(INTE_POS));

  always_ff @(posedge clk) begin
    if (rst) begin
      ibfQ    <= 1'b0;
      intrQ   <= 1'b0;
      inteQ   <= 1'b0;
      rdPrevQ <= 1'b1;
    end else begin
      rdPrevQ <= rdN;
      if (inteHit) inteQ <= bsrVal;
      // new strobe beats the end of a read
      if (!modeActive)  ibfQ <= 1'b0;
      else if (stbLow)  ibfQ <= 1'b1;
      else if (rdRise)  ibfQ <= 1'b0;
      // request only outside a read window
      intrQ <= modeActive && inteQ && ibfQ && stbN && rdN && rdPrevQ;
    end
  end

  always_comb begin
    ctrl.capture = stbLow;
    ctrl.ibf     = ibfQ;
    ctrl.intr    = intrQ;
    ctrl.inte    = inteQ;
  end
endmodule

// File: rtl/sip_datapath.sv
module sip_datapath
  import sip_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STAT_W   = 8,
  parameter int IBF_POS  = 5,
  parameter int INTR_POS = 3,
  parameter int INTE_POS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  sipCtrl_t          ctrl,
  input  logic [DATA_W-1:0] padData,
  output logic [DATA_W-1:0] dataOut,
  output logic [STAT_W-1:0] statusC
);
  logic [DATA_W-1:0] holdQ;

  always_ff @(posedge clk) begin
    if (rst)               holdQ <= '0;
    else if (ctrl.capture) holdQ <= padData;
  end

  assign dataOut = holdQ;

  always_comb begin
    statusC           = '0;
    statusC[IBF_POS]  = ctrl.ibf;
    statusC[INTR_POS] = ctrl.intr;
    statusC[INTE_POS] = ctrl.inte;
  end
endmodule

// File: rtl/strobed_input_port.sv
module strobed_input_port
  import sip_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STAT_W    = 8,
  parameter bit IS_PORT_A = 1'b1,
  parameter int BIT_W     = $clog2(STAT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeActive,
  input  logic              stbN,
  input  logic [DATA_W-1:0] padData,
  input  logic              rdN,
  input  logic              bsrWrite,
  input  logic [BIT_W-1:0]  bsrBit,
  input  logic              bsrVal,
  output logic [DATA_W-1:0] dataOut,
  output logic              ibf,
  output logic              intr,
  output logic              inte,
  output logic [STAT_W-1:0] statusC
);
  localparam int INTE_P = intePos(IS_PORT_A);
  localparam int IBF_P  = ibfPos(IS_PORT_A);
  localparam int INTR_P = intrPos(IS_PORT_A);

  sipCtrl_t ctrl;

  sip_ctrl #(.INTE_POS(INTE_P), .BIT_W(BIT_W)) uCtrl (
    .clk(clk), .rst(rst), .modeActive(modeActive), .stbN(stbN), .rdN(rdN),
    .bsrWrite(bsrWrite), .bsrBit(bsrBit), .bsrVal(bsrVal), .ctrl(ctrl)
  );

  sip_datapath #(.DATA_W(DATA_W), .STAT_W(STAT_W), .IBF_POS(IBF_P),
                 .INTR_POS(INTR_P), .INTE_POS(INTE_P)) uData (
    .clk(clk), .rst(rst), .ctrl(ctrl), .padData(padData),
    .dataOut(dataOut), .statusC(statusC)
  );

  assign ibf  = ctrl.ibf;
  assign intr = ctrl.intr;
  assign inte = ctrl.inte;
endmodule

// File: rtl/sip_checker.sv
module sip_checker #(
  parameter int DATA_W = 8,
  parameter int STAT_W = 8,
  parameter bit IS_PORT_A = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              modeActive,
  input logic              stbN,
  input logic              rdN,
  input logic [DATA_W-1:0] padData,
  input logic [DATA_W-1:0] dataOut,
  input logic              ibf,
  input logic              intr,
  input logic              inte,
  input logic [STAT_W-1:0] statusC
);
  localparam logic [STAT_W-1:0] USED_MASK = IS_PORT_A ? STAT_W'(8'h38) : STAT_W'(8'h07);

  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (!ibf && !intr && !inte && dataOut == '0)); // R1
  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst) (modeActive && !stbN) |=> (dataOut == $past(padData))); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst) stbN |=> $stable(dataOut)); // R2
  AST_IBF_SET: assert property (@(posedge clk) disable iff (rst) (modeActive && !stbN) |=> ibf); // R3
  AST_IBF_CLEAR: assert property (@(posedge clk) disable iff (rst) (stbN && rdN && !$past(rdN)) |=> !ibf); // R4
  AST_INTR_NEEDS_IBF: assert property (@(posedge clk) disable iff (rst) intr |-> ibf); // R5
  AST_INTR_READ_CLR: assert property (@(posedge clk) disable iff (rst) !rdN |=> !intr); // R6
  AST_STATUS_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst) (statusC & ~USED_MASK) == '0); // R8
  AST_MODE_OFF: assert property (@(posedge clk) disable iff (rst) !modeActive |=> (!ibf && !intr)); // R9
endmodule

bind strobed_input_port sip_checker #(.DATA_W(DATA_W), .STAT_W(STAT_W), .IS_PORT_A(IS_PORT_A)) uChk (
  .clk(clk), .rst(rst), .modeActive(modeActive), .stbN(stbN), .rdN(rdN),
  .padData(padData), .dataOut(dataOut), .ibf(ibf), .intr(intr), .inte(inte),
  .statusC(statusC)
);

// File: tb/sim_strobed_input_port.sv
`timescale 1ns/1ps
module sim_strobed_input_port;
  logic clk = 1'b0;
  logic rst;
  logic modeActive, stbN, rdN, bsrWrite, bsrVal;
  logic [7:0] padData;
  logic [2:0] bsrBit;
  logic [7:0] dataOut, statusC;
  logic ibf, intr, inte;
  // second-port variant
  logic bWrite, bVal;
  logic [2:0] bBit;
  logic [7:0] bData, bStatus;
  logic bIbf, bIntr, bInte;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference state
  logic eIbf, eIntr, eInte, eRdPrev;
  logic [7:0] eData;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  strobed_input_port #(.IS_PORT_A(1'b1)) u0 (
    .clk(clk), .rst(rst), .modeActive(modeActive), .stbN(stbN), .padData(padData),
    .rdN(rdN), .bsrWrite(bsrWrite), .bsrBit(bsrBit), .bsrVal(bsrVal),
    .dataOut(dataOut), .ibf(ibf), .intr(intr), .inte(inte), .statusC(statusC)
  );

  strobed_input_port #(.IS_PORT_A(1'b0)) u1 (
    .clk(clk), .rst(rst), .modeActive(1'b1), .stbN(1'b1), .padData(8'h00),
    .rdN(1'b1), .bsrWrite(bWrite), .bsrBit(bBit), .bsrVal(bVal),
    .dataOut(bData), .ibf(bIbf), .intr(bIntr), .inte(bInte), .statusC(bStatus)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R2 dataOut", dataOut, eData);
    chk("R3/R4 ibf", {7'd0, ibf}, {7'd0, eIbf});
    chk("R5/R6 intr", {7'd0, intr}, {7'd0, eIntr});
    chk("R7 inte", {7'd0, inte}, {7'd0, eInte});
    chk("R8 status", statusC, 8'((eIbf << 5) | (eInte << 4) | (eIntr << 3)));
  endtask

  // one clock: apply at negedge, advance model, sample after posedge
  task automatic cyc(input logic m, input logic s, input logic r, input logic [7:0] d,
                     input logic bw, input logic [2:0] bb, input logic bv);
    logic nIbf, nIntr, nInte;
    logic [7:0] nData;
    @(negedge clk);
    modeActive = m; stbN = s; rdN = r; padData = d;
    bsrWrite = bw; bsrBit = bb; bsrVal = bv;
    nInte = (bw && bb == 3'd4) ? bv : eInte;
    nData = (m && !s) ? d : eData;
    nIbf  = !m ? 1'b0 : (!s ? 1'b1 : ((r && !eRdPrev) ? 1'b0 : eIbf));
    nIntr = m && eInte && eIbf && s && r && eRdPrev;
    @(posedge clk); #1;
    eInte = nInte; eData = nData; eIbf = nIbf; eIntr = nIntr; eRdPrev = r;
    compareAll();
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; modeActive = 1'b1; stbN = 1'b1; rdN = 1'b1; padData = 8'h00;
    bsrWrite = 1'b0; bsrBit = 3'd0; bsrVal = 1'b0;
    bWrite = 1'b0; bBit = 3'd0; bVal = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    eIbf = 0; eIntr = 0; eInte = 0; eData = 8'h00; eRdPrev = 1;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    modeActive = 1'b1; stbN = 1'b1; rdN = 1'b1; padData = 8'h00;
    bsrWrite = 1'b0; bsrBit = 3'd0; bsrVal = 1'b0;
    bWrite = 1'b0; bBit = 3'd0; bVal = 1'b0;
    doReset();
    // R1: reset state
    chk("R1 reset outputs", {dataOut[3:0], ibf, intr, inte, 1'b0}, 8'h00);
    chk("R1 reset status", statusC, 8'h00);

    // directed handshake
    cyc(1, 1, 1, 8'h00, 1, 3'd4, 1);            // enable
    cyc(1, 0, 1, 8'hA5, 0, 3'd0, 0);            // strobe
    chk("R3 ibf after strobe", {7'd0, ibf}, 8'h01);
    chk("R2 data captured", dataOut, 8'hA5);
    cyc(1, 1, 1, 8'h3C, 0, 3'd0, 0);
    cyc(1, 1, 1, 8'h3C, 0, 3'd0, 0);
    chk("R5 intr raised", {7'd0, intr}, 8'h01);
    chk("R2 data held", dataOut, 8'hA5);
    chk("R8 status A", statusC, 8'h38);
    cyc(1, 1, 0, 8'h00, 0, 3'd0, 0);            // read falls
    chk("R6 intr cleared by read", {7'd0, intr}, 8'h00);
    chk("R4 ibf held during read", {7'd0, ibf}, 8'h01);
    cyc(1, 1, 1, 8'h00, 0, 3'd0, 0);            // read rises
    chk("R4 ibf cleared at read end", {7'd0, ibf}, 8'h00);

    // R4: strobe at the read's end keeps ibf set, no intr during read window
    cyc(1, 0, 1, 8'h11, 0, 3'd0, 0);
    cyc(1, 1, 0, 8'h00, 0, 3'd0, 0);
    cyc(1, 0, 1, 8'h22, 0, 3'd0, 0);
    chk("R4 set wins over read end", {7'd0, ibf}, 8'h01);
    chk("R5 no intr just after read", {7'd0, intr}, 8'h00);
    cyc(1, 1, 1, 8'h00, 0, 3'd0, 0);
    cyc(1, 1, 1, 8'h00, 0, 3'd0, 0);
    chk("R5 intr after overlap", {7'd0, intr}, 8'h01);

    // R9: mode off
    cyc(0, 0, 1, 8'h77, 0, 3'd0, 0);
    chk("R9 ibf forced low", {7'd0, ibf}, 8'h00);
    chk("R9 strobe ignored", dataOut, 8'h22);
    cyc(0, 1, 1, 8'h00, 0, 3'd0, 0);

    // R7: bit set/reset sweep on both variants
    for (int b = 0; b < 8; b++) begin
      cyc(1, 1, 1, 8'h00, 1, 3'd4, 0);
      cyc(1, 1, 1, 8'h00, 1, 3'(b), 1);
      chk("R7 port A enable index", {7'd0, inte}, {7'd0, (b == 4)});
      @(negedge clk); bWrite = 1; bBit = 3'd2; bVal = 0;
      @(negedge clk); bBit = 3'(b); bVal = 1;
      @(negedge clk); bWrite = 0;
      #1;
      chk("R7 port B enable index", {7'd0, bInte}, {7'd0, (b == 2)});
      chk("R8 status B", bStatus, (b == 2) ? 8'h04 : 8'h00);
    end

    // pseudo-random sweep against the reference model
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[3:0] != 4'h0, lfsr[5:4] != 2'b00, lfsr[7:6] != 2'b00, lfsr[15:8],
          lfsr[10:8] == 3'b000, {lfsr[11], lfsr[1], lfsr[9]}, lfsr[12]);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule